// File: doc/BRIEF.md
# Custom Instruction Execution Unit

This unit sits next to a RISC-V core and accepts instructions that the core hands off to it. Each offered instruction arrives with up to three source operand values, a mask telling which of those values are valid, the hart's current privilege level and a latency setting. In the same cycle as the offer, the unit decodes the word and answers with accept or reject, plus whether a register write will follow.

Accepted instructions produce exactly one result transaction. A result carries the destination index, the data, a write enable, an exception flag and a 6-bit exception code. The unit handles several operations. Arithmetic comes as a plain two-value add, a three-value add, and two adds restricted by privilege. There is also a delayed add whose latency is programmable, a hint that does nothing, and a trap instruction whose immediate becomes the exception code.

Only one instruction is in flight at a time. Arithmetic is modulo 2^XLEN. With NUM_SRC below 3 the three-value add is always rejected.

Top module: `cxu_exec`

## Requirements
- R1: Only words whose bits [6:0] equal 7'h7B can be accepted. A word with any other opcode is rejected, and so is a 7'h7B word that matches no operation below. A rejected word produces no result.
- R2: The plain add (bits [31:25]=7'b0000000, bits [14:12]=3'b001) is accepted at every privilege level. Its result carries rd = bits [11:7], data = op_a + op_b modulo 2^32 and write enable 1, and it is valid in the cycle after the issue handshake.
- R3: The three-value add (bits [26:25]=2'b01, bits [14:12]=3'b000) writes op_a + op_b + op_c modulo 2^32 to rd. It is accepted only when the source mask is 3'b111.
- R4: Every two-value add is accepted only when the source mask is 3'b011 or 3'b111.
- R5: Privilege is encoded 2'b00 user, 2'b01 supervisor and 2'b11 machine. The supervisor add (bits [31:25]=7'b0000110, funct3 3'b000) is accepted only at level 2'b01. The user add (bits [31:25]=7'b0000010, funct3 3'b000) is accepted only at level 2'b00. Both return op_a + op_b.
- R6: The hint (bits [31:7] all zero) is accepted with the write flag low. Its result has write enable 0 and exception flag 0.
- R7: The trap instruction (bits [31:25]=7'b1100000, bits [24:13]=12'h001) is accepted with the write flag low. Its result has exception flag 1, write enable 0, and code equal to bits [12:7].
- R8: The delayed add (bits [31:25]=7'b0001000, funct3 3'b000) returns op_a + op_b. Let L be the latency input sampled at issue, clamped to the range 1..15 (a setting of 0 counts as 1). The result becomes valid L cycles later than a single-cycle result would.
- R9: While the issue handshake happens, iss_accept and iss_wb give the decision. iss_wb is 1 only for the add operations.
- R10: iss_ready is low from an accepted issue until its result has been taken, including the whole countdown of a delayed add.
- R11: While res_valid is high and res_ready is low, every result field holds its value.
- R12: Out of reset, iss_ready is 1 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_ready | output | 1 | Unit can take an instruction |
| iss_instr | input | 32 | Instruction word |
| iss_op_a | input | XLEN | First source value |
| iss_op_b | input | XLEN | Second source value |
| iss_op_c | input | XLEN | Third source value |
| iss_src_mask | input | 3 | Validity of the three source values |
| iss_priv | input | 2 | Current privilege level |
| iss_lat | input | LAT_W | Requested delay for the delayed add |
| iss_accept | output | 1 | Offered word is accepted |
| iss_wb | output | 1 | Accepted word will write a register |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_rd | output | 5 | Destination register index |
| res_data | output | XLEN | Result value |
| res_we | output | 1 | Register write enable |
| res_exc | output | 1 | Exception flag |
| res_code | output | 6 | Exception code |

## Verification
The add datapath is driven with small positive values, a carry out of bit 31 and the sum of two most-negative values. These cases separate a correct modulo-2^32 sum from a truncated or sign-extended one. Decode is probed with near-miss words: a foreign opcode, an unknown function field, wrong source masks and every privilege level against the two restricted adds. Each of these can only be told apart by its accept bit and by the absence of a result. The delayed add runs with latency settings of 0, 7 and 15, which expose a missing clamp or an off-by-one in the countdown. A back-pressured result shows whether the fields hold and whether issue stays blocked.

// File: rtl/cxu_pkg.sv
`timescale 1ns/1ps
package cxu_pkg;
  localparam logic [6:0] CUST_OPC = 7'h7B;

  localparam logic [1:0] PRV_USER  = 2'b00;
  localparam logic [1:0] PRV_SUPER = 2'b01;

  localparam logic [6:0] F7_PLAIN = 7'b0000000;
  localparam logic [6:0] F7_SUPER = 7'b0000110;
  localparam logic [6:0] F7_USER  = 7'b0000010;
  localparam logic [6:0] F7_SLOW  = 7'b0001000;
  localparam logic [6:0] F7_TRAP  = 7'b1100000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_NOP,
    OP_ADD2,
    OP_ADD3,
    OP_SLOW,
    OP_TRAP
  } op_e;
endpackage

// File: rtl/cxu_decode.sv
`timescale 1ns/1ps
module cxu_decode
  import cxu_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic [31:0] instr,
  input  logic [2:0]  src_mask,
  input  logic [1:0]  priv,
  output op_e         op,
  output logic        accept,
  output logic        wb,
  output logic [5:0]  trap_code
);
  logic       three_cap;
  logic [6:0] f7;
  logic [2:0] f3;
  logic       two_ok;
  logic       three_ok;

  generate
    if (NUM_SRC >= 3) begin : g_three
      assign three_cap = 1'b1;
    end else begin : g_two
      assign three_cap = 1'b0;
    end
  endgenerate

  assign f7       = instr[31:25];
  assign f3       = instr[14:12];
  assign two_ok   = (src_mask == 3'b011) || (src_mask == 3'b111);
  assign three_ok = three_cap && (src_mask == 3'b111);

  // Order matters: the hint pattern is tested first, it is a subset of f7==0.
  always_comb begin
    op = OP_NONE;
    if (instr[6:0] == CUST_OPC) begin
      if (instr[31:7] == 25'd0) begin
        op = OP_NOP;
      end else if (f7 == F7_PLAIN && f3 == 3'b001) begin
        if (two_ok) op = OP_ADD2;
      end else if (f7 == F7_SUPER && f3 == 3'b000) begin
        if (two_ok && priv == PRV_SUPER) op = OP_ADD2;
      end else if (f7 == F7_USER && f3 == 3'b000) begin
        if (two_ok && priv == PRV_USER) op = OP_ADD2;
      end else if (f7 == F7_SLOW && f3 == 3'b000) begin
        if (two_ok) op = OP_SLOW;
      end else if (instr[26:25] == 2'b01 && f3 == 3'b000) begin
        if (three_ok) op = OP_ADD3;
      end else if (f7 == F7_TRAP && instr[24:13] == 12'h001) begin
        op = OP_TRAP;
      end
    end
  end

  assign accept    = (op != OP_NONE);
  assign wb        = (op == OP_ADD2) || (op == OP_ADD3) || (op == OP_SLOW);
  assign trap_code = instr[12:7];
endmodule

// File: rtl/cxu_delay.sv
`timescale 1ns/1ps
module cxu_delay #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat_in,
  output logic             busy,
  output logic             done
);
  logic [LAT_W-1:0] cnt;

  // A request of zero is raised to the minimum of one cycle.
  function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] v);
    return (v == '0) ? LAT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= clamp_lat(lat_in) - LAT_W'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - LAT_W'(1);
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/cxu_exec.sv
`timescale 1ns/1ps
module cxu_exec
  import cxu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 3,
  parameter int LAT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [31:0]      iss_instr,
  input  logic [XLEN-1:0]  iss_op_a,
  input  logic [XLEN-1:0]  iss_op_b,
  input  logic [XLEN-1:0]  iss_op_c,
  input  logic [2:0]       iss_src_mask,
  input  logic [1:0]       iss_priv,
  input  logic [LAT_W-1:0] iss_lat,
  output logic             iss_accept,
  output logic             iss_wb,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [4:0]       res_rd,
  output logic [XLEN-1:0]  res_data,
  output logic             res_we,
  output logic             res_exc,
  output logic [5:0]       res_code
);
  function automatic logic [XLEN-1:0] wrap_sum(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic [XLEN-1:0] c,
                                               input logic            use_c);
    return a + b + (use_c ? c : '0);
  endfunction

  op_e        dec_op;
  logic       dec_accept;
  logic       dec_wb;
  logic [5:0] dec_code;
  logic       issue_fire;
  logic       issue_take;
  logic       issue_fire_single;
  logic       slow_start;
  logic       dly_busy;
  logic       dly_done;
  logic       res_valid_q;

  cxu_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .instr     (iss_instr),
    .src_mask  (iss_src_mask),
    .priv      (iss_priv),
    .op        (dec_op),
    .accept    (dec_accept),
    .wb        (dec_wb),
    .trap_code (dec_code)
  );

  assign issue_fire        = iss_valid && iss_ready;
  assign issue_take        = issue_fire && dec_accept;
  assign slow_start        = issue_take && (dec_op == OP_SLOW);
  assign issue_fire_single = issue_take && (dec_op != OP_SLOW);

  cxu_delay #(.LAT_W(LAT_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (slow_start),
    .lat_in (iss_lat),
    .busy   (dly_busy),
    .done   (dly_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_rd      <= '0;
      res_data    <= '0;
      res_we      <= 1'b0;
      res_exc     <= 1'b0;
      res_code    <= '0;
    end else begin
      if (issue_take) begin
        res_rd   <= dec_wb ? iss_instr[11:7] : 5'd0;
        res_we   <= dec_wb;
        res_exc  <= (dec_op == OP_TRAP);
        res_code <= (dec_op == OP_TRAP) ? dec_code : 6'd0;
        if (dec_wb) res_data <= wrap_sum(iss_op_a, iss_op_b, iss_op_c, dec_op == OP_ADD3);
        else        res_data <= '0;
      end
      if (issue_fire_single || dly_done) res_valid_q <= 1'b1;
      else if (res_valid_q && res_ready) res_valid_q <= 1'b0;
    end
  end

  assign res_valid  = res_valid_q;
  assign iss_ready  = !dly_busy && !res_valid_q;
  assign iss_accept = dec_accept;
  assign iss_wb     = dec_wb;
endmodule

// File: rtl/cxu_exec_chk.sv
`timescale 1ns/1ps
module cxu_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [31:0]     iss_instr,
  input logic            iss_accept,
  input logic            res_valid,
  input logic            res_ready,
  input logic [4:0]      res_rd,
  input logic [XLEN-1:0] res_data,
  input logic            res_we,
  input logic            res_exc,
  input logic [5:0]      res_code,
  input logic            single_go,
  input logic            slow_busy
);
  assert_opcode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_instr[6:0] != 7'h7B) |-> !iss_accept);

  assert_single_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    single_go |=> res_valid);

  assert_trap_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_exc) |-> !res_we);

  assert_count_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slow_busy |-> !res_valid);

  assert_reject_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_accept) |=> !res_valid);

  assert_one_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_accept) |=> !iss_ready);

  assert_hold_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_rd)
      && $stable(res_we) && $stable(res_exc) && $stable(res_code)));
endmodule

bind cxu_exec cxu_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_instr  (iss_instr),
  .iss_accept (iss_accept),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_rd     (res_rd),
  .res_data   (res_data),
  .res_we     (res_we),
  .res_exc    (res_exc),
  .res_code   (res_code),
  .single_go  (issue_fire_single),
  .slow_busy  (dly_busy)
);

// File: tb/tb_cxu_exec.sv
`timescale 1ns/1ps
module tb_cxu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [31:0] iss_instr = '0;
  logic [31:0] iss_op_a = '0, iss_op_b = '0, iss_op_c = '0;
  logic [2:0]  iss_src_mask = '0;
  logic [1:0]  iss_priv = '0;
  logic [3:0]  iss_lat = '0;
  logic        iss_accept, iss_wb;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [4:0]  res_rd;
  logic [31:0] res_data;
  logic        res_we, res_exc;
  logic [5:0]  res_code;

  always #5 clk = ~clk;

  cxu_exec dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_instr(iss_instr), .iss_op_a(iss_op_a), .iss_op_b(iss_op_b), .iss_op_c(iss_op_c),
    .iss_src_mask(iss_src_mask), .iss_priv(iss_priv), .iss_lat(iss_lat),
    .iss_accept(iss_accept), .iss_wb(iss_wb), .res_valid(res_valid), .res_ready(res_ready),
    .res_rd(res_rd), .res_data(res_data), .res_we(res_we), .res_exc(res_exc), .res_code(res_code)
  );

  typedef struct packed {
    logic [4:0]  rd;
    logic [31:0] data;
    logic        we;
    logic        exc;
    logic [5:0]  code;
    logic [31:0] due;
  } exp_t;

  exp_t  sq[$];
  string tq[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] r_word(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, 5'd2, 5'd1, f3, rd, 7'h7B};
  endfunction

  function automatic exp_t mk(input logic [4:0] rd, input logic [31:0] d, input logic we,
                              input logic exc, input logic [5:0] code);
    exp_t e;
    e.rd = rd; e.data = d; e.we = we; e.exc = exc; e.code = code; e.due = '0;
    return e;
  endfunction

  // Driver: offers one word, checks the decision, and queues the expected result.
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [2:0] m, input logic [1:0] p,
                       input logic [3:0] lat, input bit acc, input bit wb, input exp_t e,
                       input int extra, input string req);
    exp_t x;
    @(negedge clk);
    while (!iss_ready) @(negedge clk);
    iss_instr = ins; iss_op_a = a; iss_op_b = b; iss_op_c = c;
    iss_src_mask = m; iss_priv = p; iss_lat = lat; iss_valid = 1'b1;
    #1;
    chk(iss_accept == acc, req, "accept", iss_accept, acc);
    if (acc) begin
      chk(iss_wb == wb, req, "wb flag", iss_wb, wb);
      x = e;
      x.due = cyc + 1 + extra;
      sq.push_back(x);
      tq.push_back(req);
    end
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  // Monitor: compares results against the scoreboard as they appear.
  bit          first_seen = 1'b0;
  bit          held = 1'b0;
  logic [31:0] h_data;
  logic [4:0]  h_rd;
  logic        h_we, h_exc;
  logic [5:0]  h_code;

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sq.size() == 0) begin
        chk(1'b0, "R9", "result with nothing accepted", 1, 0);
      end else begin
        if (!first_seen) begin
          chk(cyc == int'(sq[0].due), tq[0], "result cycle", cyc, sq[0].due);
          first_seen = 1'b1;
        end
        if (held)
          chk(res_data == h_data && res_rd == h_rd && res_we == h_we && res_exc == h_exc
              && res_code == h_code, "R11", "held fields", res_data, h_data);
        if (res_ready) begin
          chk(res_we == sq[0].we, tq[0], "write enable", res_we, sq[0].we);
          chk(res_exc == sq[0].exc, tq[0], "exception flag", res_exc, sq[0].exc);
          if (sq[0].we) begin
            chk(res_data == sq[0].data, tq[0], "data", res_data, sq[0].data);
            chk(res_rd == sq[0].rd, tq[0], "rd", res_rd, sq[0].rd);
          end
          if (sq[0].exc) chk(res_code == sq[0].code, tq[0], "code", res_code, sq[0].code);
          void'(sq.pop_front());
          void'(tq.pop_front());
          first_seen = 1'b0;
          held = 1'b0;
        end else begin
          held = 1'b1;
          h_data = res_data; h_rd = res_rd; h_we = res_we; h_exc = res_exc; h_code = res_code;
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_ready == 1'b1, "R12", "ready after reset", iss_ready, 1);
    chk(res_valid == 1'b0, "R12", "valid after reset", res_valid, 0);

    // R2 plain add at three privilege levels, including wrap-around
    issue(r_word(7'b0000000, 3'b001, 5'd3), 32'd5, 32'd7, 32'd0, 3'b011, 2'b11, 4'd0, 1, 1,
          mk(5'd3, 32'd12, 1, 0, 0), 0, "R2");
    issue(r_word(7'b0000000, 3'b001, 5'd9), 32'hFFFF_FFFF, 32'd2, 32'd0, 3'b011, 2'b00, 4'd0, 1, 1,
          mk(5'd9, 32'd1, 1, 0, 0), 0, "R2");
    issue(r_word(7'b0000000, 3'b001, 5'd31), 32'h8000_0000, 32'h8000_0000, 32'd0, 3'b011, 2'b01, 4'd0, 1, 1,
          mk(5'd31, 32'd0, 1, 0, 0), 0, "R2");

    // R1 foreign opcode and unknown function field
    w = r_word(7'b0000000, 3'b001, 5'd3);
    w[6:0] = 7'h33;
    issue(w, 32'd1, 32'd1, 32'd0, 3'b011, 2'b11, 4'd0, 0, 0, mk(0, 0, 0, 0, 0), 0, "R1");
    issue(r_word(7'b0000001, 3'b001, 5'd3), 32'd1, 32'd1, 32'd0, 3'b011, 2'b11, 4'd0, 0, 0,
          mk(0, 0, 0, 0, 0), 0, "R1");

    // R4 source mask gating
    issue(r_word(7'b0000000, 3'b001, 5'd4), 32'd1, 32'd1, 32'd0, 3'b001, 2'b11, 4'd0, 0, 0,
          mk(0, 0, 0, 0, 0), 0, "R4");
    issue(r_word(7'b0000000, 3'b001, 5'd4), 32'd10, 32'd20, 32'd0, 3'b111, 2'b11, 4'd0, 1, 1,
          mk(5'd4, 32'd30, 1, 0, 0), 0, "R4");

    // R5 privilege-restricted adds
    issue(r_word(7'b0000110, 3'b000, 5'd5), 32'd100, 32'hFFFF_FFFF, 32'd0, 3'b011, 2'b01, 4'd0, 1, 1,
          mk(5'd5, 32'd99, 1, 0, 0), 0, "R5");
    issue(r_word(7'b0000110, 3'b000, 5'd5), 32'd1, 32'd1, 32'd0, 3'b011, 2'b00, 4'd0, 0, 0,
          mk(0, 0, 0, 0, 0), 0, "R5");
    issue(r_word(7'b0000110, 3'b000, 5'd5), 32'd1, 32'd1, 32'd0, 3'b011, 2'b11, 4'd0, 0, 0,
          mk(0, 0, 0, 0, 0), 0, "R5");
    issue(r_word(7'b0000010, 3'b000, 5'd6), 32'h1234_0000, 32'h0000_5678, 32'd0, 3'b011, 2'b00, 4'd0, 1, 1,
          mk(5'd6, 32'h1234_5678, 1, 0, 0), 0, "R5");
    issue(r_word(7'b0000010, 3'b000, 5'd6), 32'd1, 32'd1, 32'd0, 3'b011, 2'b01, 4'd0, 0, 0,
          mk(0, 0, 0, 0, 0), 0, "R5");

    // R3 three-value add
    issue({5'd7, 2'b01, 5'd2, 5'd1, 3'b000, 5'd8, 7'h7B}, 32'd1, 32'd2, 32'hFFFF_FFFF, 3'b111, 2'b11, 4'd0,
          1, 1, mk(5'd8, 32'd2, 1, 0, 0), 0, "R3");
    issue({5'd7, 2'b01, 5'd2, 5'd1, 3'b000, 5'd8, 7'h7B}, 32'd1, 32'd2, 32'd3, 3'b011, 2'b11, 4'd0,
          0, 0, mk(0, 0, 0, 0, 0), 0, "R3");

    // R6 hint
    issue({25'd0, 7'h7B}, 32'd5, 32'd5, 32'd0, 3'b000, 2'b00, 4'd0, 1, 0, mk(0, 0, 0, 0, 0), 0, "R6");

    // R7 trap with three immediates
    issue({7'b1100000, 12'h001, 6'h2A, 7'h7B}, 32'd0, 32'd0, 32'd0, 3'b000, 2'b11, 4'd0, 1, 0,
          mk(0, 0, 0, 1, 6'h2A), 0, "R7");
    issue({7'b1100000, 12'h001, 6'h00, 7'h7B}, 32'd0, 32'd0, 32'd0, 3'b000, 2'b00, 4'd0, 1, 0,
          mk(0, 0, 0, 1, 6'h00), 0, "R7");
    issue({7'b1100000, 12'h001, 6'h3F, 7'h7B}, 32'd0, 32'd0, 32'd0, 3'b000, 2'b01, 4'd0, 1, 0,
          mk(0, 0, 0, 1, 6'h3F), 0, "R7");

    // R8 delayed add; R10 ready stays low while counting
    issue(r_word(7'b0001000, 3'b000, 5'd10), 32'd40, 32'd2, 32'd0, 3'b011, 2'b11, 4'd7, 1, 1,
          mk(5'd10, 32'd42, 1, 0, 0), 7, "R8");
    @(negedge clk);
    chk(iss_ready == 1'b0, "R10", "ready during countdown", iss_ready, 0);
    issue(r_word(7'b0001000, 3'b000, 5'd11), 32'hFFFF_FFF0, 32'h20, 32'd0, 3'b111, 2'b00, 4'd0, 1, 1,
          mk(5'd11, 32'h10, 1, 0, 0), 1, "R8");
    issue(r_word(7'b0001000, 3'b000, 5'd12), 32'd3, 32'd4, 32'd0, 3'b011, 2'b01, 4'd15, 1, 1,
          mk(5'd12, 32'd7, 1, 0, 0), 15, "R8");

    // R11 back-pressure, R10 ready low while a result waits
    @(negedge clk);
    while (!iss_ready) @(negedge clk);
    res_ready = 1'b0;
    issue(r_word(7'b0000000, 3'b001, 5'd13), 32'hA5A5_0000, 32'h0000_5A5A, 32'd0, 3'b011, 2'b11, 4'd0, 1, 1,
          mk(5'd13, 32'hA5A5_5A5A, 1, 0, 0), 0, "R11");
    repeat (4) @(negedge clk);
    chk(iss_ready == 1'b0, "R10", "ready while result waits", iss_ready, 0);
    res_ready = 1'b1;

    for (int i = 0; i < 100 && sq.size() != 0; i++) @(negedge clk);
    chk(sq.size() == 0, "R9", "results drained", sq.size(), 0);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule